// File: doc/BRIEF.md
# Configuration Packet Stream Decoder

This block sits on a 32-bit configuration word stream with a valid/ready handshake. While unsynchronized it throws away every incoming word (filler, bus-width probing words, anything else) and watches for the synchronization word `0xAA995566`. Once that word is seen, each following word is taken as a packet header. Header fields are: type in bits [31:29], opcode in [28:27], register address in [26:13], reserved bits in [12:11] and word count in [10:0].

A write header sends the word-count payload words that follow into a bank of 19 configuration registers. The registers are addressed 0 to 18. Address 4 is the command register and address 12 is the identification register. A read header stops the input stream and plays the addressed register out on a separate readback stream, once for each counted word. Writing the leave-sync code `0x0000000D` to the command register drops the block back to hunting for the synchronization word. Malformed headers and undefined addresses set a sticky error flag.

Top module: `cfg_stream_decoder`

## Requirements
- R1: While unsynchronized, every accepted word is discarded: all-ones filler, `0x000000BB`, `0x11220044` and even well-formed headers. `synced` stays 0, no readback word appears, `err` stays 0 and no register changes.
- R2: Accepting `0xAA995566` while unsynchronized raises `synced` on the next cycle, and the next accepted word is decoded as a header.
- R3: A header of type 001 with opcode 00 or 11 (for example the no-op `0x20000000`) is consumed alone with no effect. The word after it is again a header.
- R4: A header of type 001 with opcode 10, a defined address A and word count N > 0 writes the next N accepted words into register A in order. The last word wins. After that a header is expected again.
- R5: A header of type 001 with opcode 01, a defined address A and count N makes the readback stream deliver exactly N words, each equal to register A. `in_ready` is 0 until the last of them is taken. When N = 0, nothing is delivered and `in_ready` stays 1.
- R6: A readback word that is not accepted (`rb_ready` low) stays valid with unchanged data.
- R7: A payload word `0x0000000D` written to register 4 stores the value, clears `synced` on the next cycle and returns the block to hunting. Other register contents are kept.
- R8: `err` is set and holds until reset when any of these is accepted as a header: a type other than 001, nonzero reserved bits [12:11], or a read/write to an address above 18. A read of an undefined address returns zero words. A write to one swallows its payload without changing any register.
- R9: Register 12 stores only the low 28 bits of a written word. Its upper four bits always read back as 0.
- R10: After reset, `synced`, `err` and `rb_valid` are 0, `in_ready` is 1 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 32 | Configuration word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| rb_data | output | 32 | Readback word |
| rb_valid | output | 1 | Readback word valid |
| rb_ready | input | 1 | Consumer takes the readback word |
| synced | output | 1 | Synchronization word seen; headers are being decoded |
| err | output | 1 | Sticky packet error flag |

## Verification
A wrong decode state shows up within one accepted word. If the block believes it is synchronized too early, a header sent before the sync word yields readback words. If it believes it has lost sync, reads after the sync word yield nothing. A word counter that is off by one shows as an extra or missing readback word, or as a payload word decoded as a header, at the next exchange. A corrupted register bank is visible only when that register is read back, so every write is followed by a read of the same address.

// File: rtl/cfg_stream_decoder.sv
module cfg_stream_decoder #(
  parameter int          NREGS       = 19,
  parameter int          WC_W        = 11,
  parameter logic [31:0] SYNC_WORD   = 32'hAA995566,
  parameter int          CMD_ADDR    = 4,
  parameter logic [31:0] DESYNC_CODE = 32'h0000000D,
  parameter int          ID_ADDR     = 12,
  parameter logic [31:0] ID_MASK     = 32'h0FFFFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [31:0] rb_data,
  output logic        rb_valid,
  input  logic        rb_ready,
  output logic        synced,
  output logic        err
);
  localparam int AW = 14;
  localparam int IW = $clog2(NREGS);

  typedef enum logic [1:0] {S_HUNT, S_HDR, S_WR, S_RD} st_t;

  st_t             st;
  logic [AW-1:0]   addr;
  logic [WC_W-1:0] cnt;
  logic [31:0]     bank [NREGS];
  logic            err_q;

  wire            acc     = in_valid & in_ready;
  wire [2:0]      h_type  = in_data[31:29];
  wire [1:0]      h_op    = in_data[28:27];
  wire [AW-1:0]   h_addr  = in_data[26:13];
  wire [1:0]      h_rsv   = in_data[12:11];
  wire [WC_W-1:0] h_wc    = in_data[WC_W-1:0];
  wire            h_ok    = h_addr < AW'(NREGS);
  wire            tgt_ok  = addr < AW'(NREGS);
  wire [IW-1:0]   idx     = addr[IW-1:0];
  wire            bank_we = (st == S_WR) && acc && tgt_ok;
  wire            desync  = bank_we && (addr == AW'(CMD_ADDR)) && (in_data == DESYNC_CODE);

  assign in_ready = (st != S_RD);
  assign rb_valid = (st == S_RD);
  assign rb_data  = rb_valid ? bank[idx] : '0;
  assign synced   = (st != S_HUNT);
  assign err      = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_HUNT;
      addr  <= '0;
      cnt   <= '0;
      err_q <= 1'b0;
    end else begin
      case (st)
        S_HUNT: if (acc && in_data == SYNC_WORD) st <= S_HDR;
        S_HDR: if (acc) begin
          addr <= h_addr;
          cnt  <= h_wc;
          if (h_type != 3'b001 || h_rsv != 2'b00) err_q <= 1'b1;
          else if (h_op == 2'b01) begin
            if (!h_ok) err_q <= 1'b1;
            else if (h_wc != '0) st <= S_RD;
          end else if (h_op == 2'b10) begin
            if (!h_ok) err_q <= 1'b1;
            if (h_wc != '0) st <= S_WR;
          end
        end
        S_WR: if (acc) begin
          cnt <= cnt - 1'b1;
          if (desync) st <= S_HUNT;
          else if (cnt == WC_W'(1)) st <= S_HDR;
        end
        S_RD: if (rb_ready) begin
          cnt <= cnt - 1'b1;
          if (cnt == WC_W'(1)) st <= S_HDR;
        end
        default: st <= S_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) bank[i] <= '0;
    end else if (bank_we) begin
      bank[idx] <= (idx == IW'(ID_ADDR)) ? (in_data & ID_MASK) : in_data;
    end
  end

  p_hunt_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !rb_valid);
  p_sync_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!synced && in_valid && in_ready && in_data == SYNC_WORD) |=> synced);
  p_rd_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> !in_ready);
  p_rb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && !rb_ready) |=> (rb_valid && $stable(rb_data)));
  p_desync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    desync |=> !synced);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_id_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && addr == AW'(ID_ADDR)) |-> (rb_data & ~ID_MASK) == 32'h0);
endmodule

// File: tb/tb_cfg_stream_decoder.sv
module tb_cfg_stream_decoder;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic [31:0] in_data = '0;
  logic        in_valid = 0, rb_ready = 0;
  logic        in_ready, rb_valid, synced, err;
  logic [31:0] rb_data;
  int n_chk = 0, n_fail = 0;

  cfg_stream_decoder dut (.clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .rb_data(rb_data), .rb_valid(rb_valid), .rb_ready(rb_ready),
    .synced(synced), .err(err));

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P*100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_hdr(input int a, input int n);
    return 32'h28000000 | (32'(a) << 13) | 32'(n);
  endfunction
  function automatic logic [31:0] wr_hdr(input int a, input int n);
    return 32'h30000000 | (32'(a) << 13) | 32'(n);
  endfunction

  task automatic do_reset();
    rst_n = 0; in_valid = 0; rb_ready = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w);
    in_data = w; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic read_chk(input int a, input int n, input logic [31:0] exp, input string req);
    send(rd_hdr(a, n));
    rb_ready = 1;
    for (int i = 0; i < n; i++) begin
      chk(rb_valid && !in_ready, req, {30'd0, rb_valid, in_ready}, 32'h2);
      chk(rb_data == exp, req, rb_data, exp);
      @(negedge clk);
    end
    chk(!rb_valid && in_ready, req, {30'd0, rb_valid, in_ready}, 32'h1);
    rb_ready = 0;
  endtask

  task automatic t_reset();
    chk(!synced && !err && !rb_valid && in_ready, "R10",
        {28'd0, synced, err, rb_valid, in_ready}, 32'h1);
    send(32'hAA995566);
    read_chk(5, 1, 32'h0, "R10");
    read_chk(18, 1, 32'h0, "R10");
  endtask

  task automatic t_hunt();
    do_reset();
    for (int i = 0; i < 8; i++) send(32'hFFFFFFFF);
    send(32'h000000BB);
    send(32'h11220044);
    send(32'hFFFFFFFF);
    send(wr_hdr(5, 1));
    send(32'h12345678);
    send(rd_hdr(5, 1));
    @(negedge clk);
    chk(!synced && !rb_valid && !err, "R1", {29'd0, synced, rb_valid, err}, 32'h0);
    send(32'hAA995566);
    chk(synced, "R2", {31'd0, synced}, 32'h1);
    read_chk(5, 1, 32'h0, "R1");
  endtask

  task automatic t_nop_write_read();
    send(32'h20000000);
    send(32'h38000003);
    chk(synced && !err && !rb_valid, "R3", {29'd0, synced, err, rb_valid}, 32'h4);
    send(wr_hdr(5, 2));
    send(32'hAAAA0001);
    send(32'hBBBB0002);
    read_chk(5, 1, 32'hBBBB0002, "R4");
    send(wr_hdr(15, 1));
    send(32'hC0FFEE15);
    read_chk(15, 3, 32'hC0FFEE15, "R5");
    read_chk(15, 0, 32'h0, "R5");
    read_chk(5, 1, 32'hBBBB0002, "R3");
  endtask

  task automatic t_stall();
    send(rd_hdr(15, 2));
    repeat (3) begin
      chk(rb_valid && rb_data == 32'hC0FFEE15 && !in_ready, "R6", rb_data, 32'hC0FFEE15);
      @(negedge clk);
    end
    rb_ready = 1;
    @(negedge clk);
    chk(rb_valid && rb_data == 32'hC0FFEE15, "R6", rb_data, 32'hC0FFEE15);
    @(negedge clk);
    chk(!rb_valid, "R6", {31'd0, rb_valid}, 32'h0);
    rb_ready = 0;
  endtask

  task automatic t_idcode();
    send(wr_hdr(12, 1));
    send(32'hF3631093);
    read_chk(12, 1, 32'h03631093, "R9");
  endtask

  task automatic t_desync();
    send(wr_hdr(4, 1));
    send(32'h0000000D);
    chk(!synced, "R7", {31'd0, synced}, 32'h0);
    send(rd_hdr(5, 1));
    @(negedge clk);
    chk(!rb_valid, "R7", {31'd0, rb_valid}, 32'h0);
    send(32'hAA995566);
    read_chk(4, 1, 32'h0000000D, "R7");
    read_chk(5, 1, 32'hBBBB0002, "R7");
  endtask

  task automatic t_errors();
    do_reset();
    send(32'hAA995566);
    send(rd_hdr(19, 2));
    @(negedge clk);
    chk(err && !rb_valid && in_ready, "R8", {29'd0, err, rb_valid, in_ready}, 32'h5);
    send(wr_hdr(20, 1));
    send(32'hDEADBEEF);
    read_chk(5, 1, 32'h0, "R8");
    read_chk(18, 1, 32'h0, "R8");
    repeat (3) @(negedge clk);
    chk(err, "R8", {31'd0, err}, 32'h1);
    do_reset();
    send(32'hAA995566);
    send(32'h40000000);
    chk(err, "R8", {31'd0, err}, 32'h1);
    do_reset();
    send(32'hAA995566);
    send(rd_hdr(5, 1) | 32'h00000800);
    @(negedge clk);
    chk(err && !rb_valid, "R8", {30'd0, err, rb_valid}, 32'h2);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_hunt();
    t_nop_write_read();
    t_stall();
    t_idcode();
    t_desync();
    t_errors();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule